// File: doc/BRIEF.md
# DRAM Bank Row-Access Sequencer

This block drives one DRAM bank. It takes word read and write requests over a valid/ready handshake and turns each one into the commands the bank needs. A row must be opened before any column inside it can be reached, and a row must be closed before a different row can be opened. The controller remembers which row is open. A request to that row is served by a column command alone. A request to another row closes the open one, opens the new one, and then issues the column command. A request made while no row is open starts at the open step.

The device interface has one strobe per command, a narrow address bus and a data bus. The row number travels on the address bus with the open strobe, and the column number travels on the same bus later with the read or write strobe. Three parameters set a minimum wait in cycles after each kind of command before the command that depends on it. Read data comes back to the requester with a one-cycle valid pulse, a fixed number of cycles after the read strobe.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, no row is open, no strobe is active, `req_ready` is 1 and `resp_valid` is 0. The first request after reset issues an open followed by its column command, with no close.
- R2: At most one of `dev_act`, `dev_pre`, `dev_rd` and `dev_wr` is high in any cycle.
- R3: A request to the row that is already open produces exactly one command: `dev_rd` if `req_write`=0, `dev_wr` if `req_write`=1.
- R4: A request to a different row while a row is open produces exactly three commands, in this order: `dev_pre`, `dev_act`, then the column command. An open is never issued while a row is open, and a column command is never issued while no row is open.
- R5: `req_addr` holds the row in its upper ROW_W bits and the column in its lower COL_W bits. During `dev_act`, `dev_addr` carries the zero-extended row. During `dev_rd` or `dev_wr`, it carries the zero-extended column.
- R6: An open comes exactly T_PRE cycles after its close. A column command comes exactly T_ACT cycles after its open. Any command comes at least T_COL cycles after the previous column command.
- R7: During `dev_wr`, `dev_wdata` carries the write data of the request.
- R8: `resp_valid` is high for one cycle, exactly RD_LAT cycles after each `dev_rd`. In that cycle `resp_rdata` carries `dev_rdata`, so data written earlier reads back unchanged.
- R9: `req_ready` is low while a command sequence or a wait count is in progress. It is never high in a cycle that carries a strobe.
- R10: The first command of an accepted request appears in the cycle right after the handshake edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | {row, column} |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Read data valid pulse |
| resp_rdata | output | DATA_W | Read data |
| dev_act | output | 1 | Row open strobe |
| dev_pre | output | 1 | Row close strobe |
| dev_rd | output | 1 | Column read strobe |
| dev_wr | output | 1 | Column write strobe |
| dev_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| dev_wdata | output | DATA_W | Write data to the bank |
| dev_rdata | input | DATA_W | Read data from the bank |

## Verification
The bench writes every word of a small bank and then reads the words back in a strided order that changes row on almost every request. It ends with runs of same-row reads and with alternating write/read pairs that move between rows. A controller that forgot to close a row would show an open with no preceding close, and one that skipped the open on a new row would read from the wrong row, so the data comparison would fail. An off-by-one in any of the three wait counts would move a strobe by one cycle, and the exact-spacing checks would catch it. A wrong read return delay would move the response pulse away from its expected cycle. The very first request after reset is checked for an open with no close in front of it.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLOSE = 2'd1,
        ST_OPEN  = 2'd2,
        ST_COL   = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic close_row;
        logic open_row;
        logic col_rd;
        logic col_wr;
    } dev_cmd_t;

    function automatic int max_w(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dbs_wait_timer.sv
module dbs_wait_timer #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/dbs_open_row.sv
module dbs_open_row #(
    parameter int ROW_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic             clr,
    input  logic [ROW_W-1:0] row_in,
    output logic             valid,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            row   <= '0;
        end else if (set) begin
            valid <= 1'b1;
            row   <= row_in;
        end else if (clr) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/dbs_rd_pipe.sv
module dbs_rd_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic issue,
    output logic ret
);
    logic [LAT-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
        end else begin
            stage[0] <= issue;
            for (int i = 1; i < LAT; i++)
                stage[i] <= stage[i-1];
        end
    end

    assign ret = stage[LAT-1];
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq #(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 3,
    parameter int DATA_W = 8,
    parameter int T_ACT  = 3,
    parameter int T_PRE  = 2,
    parameter int T_COL  = 2,
    parameter int RD_LAT = 2
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     req_valid,
    output logic                                     req_ready,
    input  logic                                     req_write,
    input  logic [ROW_W+COL_W-1:0]                   req_addr,
    input  logic [DATA_W-1:0]                        req_wdata,
    output logic                                     resp_valid,
    output logic [DATA_W-1:0]                        resp_rdata,
    output logic                                     dev_act,
    output logic                                     dev_pre,
    output logic                                     dev_rd,
    output logic                                     dev_wr,
    output logic [dbs_pkg::max_w(ROW_W,COL_W)-1:0]   dev_addr,
    output logic [DATA_W-1:0]                        dev_wdata,
    input  logic [DATA_W-1:0]                        dev_rdata
);
    import dbs_pkg::*;

    localparam int DEV_AW = max_w(ROW_W, COL_W);
    localparam int T_MAX  = max_w(max_w(T_ACT, T_PRE), T_COL);
    localparam int CW     = $clog2(T_MAX + 1);
    localparam logic [CW-1:0] W_PRE = CW'(T_PRE - 1);
    localparam logic [CW-1:0] W_ACT = CW'(T_ACT - 1);
    localparam logic [CW-1:0] W_COL = CW'(T_COL - 1);

    seq_state_t        state, state_nx;
    logic              q_write;
    logic [ROW_W-1:0]  q_row;
    logic [COL_W-1:0]  q_col;
    logic [DATA_W-1:0] q_wdata;

    logic              wait_busy, wait_load;
    logic [CW-1:0]     wait_val;
    logic              open_v;
    logic [ROW_W-1:0]  open_r;
    logic              issue, accept;
    dev_cmd_t          cmd;

    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    assign in_row = req_addr[ROW_W+COL_W-1:COL_W];
    assign in_col = req_addr[COL_W-1:0];

    assign req_ready = (state == ST_IDLE) && !wait_busy;
    assign accept    = req_valid && req_ready;
    assign issue     = (state != ST_IDLE) && !wait_busy;

    // command decode from phase
    always_comb begin
        cmd = '0;
        case (state)
            ST_CLOSE: cmd.close_row = issue;
            ST_OPEN:  cmd.open_row  = issue;
            ST_COL: begin
                cmd.col_rd = issue && !q_write;
                cmd.col_wr = issue &&  q_write;
            end
            default: cmd = '0;
        endcase
    end

    // phase sequencing and wait loading
    always_comb begin
        state_nx  = state;
        wait_load = 1'b0;
        wait_val  = '0;
        case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (open_v && open_r == in_row)
                        state_nx = ST_COL;
                    else if (open_v)
                        state_nx = ST_CLOSE;
                    else
                        state_nx = ST_OPEN;
                end
            end
            ST_CLOSE: if (issue) begin
                state_nx  = ST_OPEN;
                wait_load = 1'b1;
                wait_val  = W_PRE;
            end
            ST_OPEN: if (issue) begin
                state_nx  = ST_COL;
                wait_load = 1'b1;
                wait_val  = W_ACT;
            end
            ST_COL: if (issue) begin
                state_nx  = ST_IDLE;
                wait_load = 1'b1;
                wait_val  = W_COL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            q_write <= 1'b0;
            q_row   <= '0;
            q_col   <= '0;
            q_wdata <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                q_write <= req_write;
                q_row   <= in_row;
                q_col   <= in_col;
                q_wdata <= req_wdata;
            end
        end
    end

    dbs_wait_timer #(.CW(CW)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .busy     (wait_busy)
    );

    dbs_open_row #(.ROW_W(ROW_W)) u_open (
        .clk    (clk),
        .rst    (rst),
        .set    (cmd.open_row),
        .clr    (cmd.close_row),
        .row_in (q_row),
        .valid  (open_v),
        .row    (open_r)
    );

    dbs_rd_pipe #(.LAT(RD_LAT)) u_rdret (
        .clk   (clk),
        .rst   (rst),
        .issue (cmd.col_rd),
        .ret   (resp_valid)
    );

    assign dev_act   = cmd.open_row;
    assign dev_pre   = cmd.close_row;
    assign dev_rd    = cmd.col_rd;
    assign dev_wr    = cmd.col_wr;
    assign dev_wdata = cmd.col_wr ? q_wdata : '0;
    assign resp_rdata = dev_rdata;

    always_comb begin
        dev_addr = '0;
        if (cmd.open_row)
            dev_addr = DEV_AW'(q_row);
        else if (cmd.col_rd || cmd.col_wr)
            dev_addr = DEV_AW'(q_col);
    end
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
    parameter int T_ACT  = 3,
    parameter int T_PRE  = 2,
    parameter int T_COL  = 2,
    parameter int RD_LAT = 2
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic dev_act,
    input logic dev_pre,
    input logic dev_rd,
    input logic dev_wr,
    input logic resp_valid
);
    logic [7:0]        since_pre, since_act, since_col;
    logic              seen_pre, seen_col, row_open;
    logic [RD_LAT-1:0] rd_hist;
    logic              any_cmd, col_cmd;

    assign any_cmd = dev_act | dev_pre | dev_rd | dev_wr;
    assign col_cmd = dev_rd | dev_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre <= '0; since_act <= '0; since_col <= '0;
            seen_pre  <= 1'b0; seen_col <= 1'b0; row_open <= 1'b0;
            rd_hist   <= '0;
        end else begin
            since_pre <= dev_pre ? 8'd1 : (since_pre != 8'hFF ? since_pre + 8'd1 : since_pre);
            since_act <= dev_act ? 8'd1 : (since_act != 8'hFF ? since_act + 8'd1 : since_act);
            since_col <= col_cmd ? 8'd1 : (since_col != 8'hFF ? since_col + 8'd1 : since_col);
            if (dev_pre) seen_pre <= 1'b1;
            if (col_cmd) seen_col <= 1'b1;
            if (dev_act) row_open <= 1'b1;
            else if (dev_pre) row_open <= 1'b0;
            rd_hist[0] <= dev_rd;
            for (int i = 1; i < RD_LAT; i++)
                rd_hist[i] <= rd_hist[i-1];
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({dev_act, dev_pre, dev_rd, dev_wr}) <= 1); // R2
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !any_cmd); // R9
    AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> any_cmd); // R10
    AST_CLOSE_TO_OPEN: assert property (@(posedge clk) disable iff (rst)
        (dev_act && seen_pre) |-> (since_pre >= 8'(T_PRE))); // R6
    AST_OPEN_TO_COL: assert property (@(posedge clk) disable iff (rst)
        col_cmd |-> (since_act >= 8'(T_ACT))); // R6
    AST_COL_TO_NEXT: assert property (@(posedge clk) disable iff (rst)
        (any_cmd && seen_col) |-> (since_col >= 8'(T_COL))); // R6
    AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (rst)
        col_cmd |-> row_open); // R4
    AST_OPEN_NEEDS_CLOSED: assert property (@(posedge clk) disable iff (rst)
        dev_act |-> !row_open); // R4
    AST_RESP_DELAY: assert property (@(posedge clk) disable iff (rst)
        resp_valid == rd_hist[RD_LAT-1]); // R8
endmodule

bind dram_bank_seq dbs_checker #(
    .T_ACT(T_ACT), .T_PRE(T_PRE), .T_COL(T_COL), .RD_LAT(RD_LAT)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .dev_act(dev_act), .dev_pre(dev_pre), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .resp_valid(resp_valid)
);

// File: tb/dram_bank_seq_test.sv
module dram_bank_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 3;
    localparam int DATA_W = 8;
    localparam int T_ACT  = 3;
    localparam int T_PRE  = 2;
    localparam int T_COL  = 2;
    localparam int RD_LAT = 2;
    localparam int AW     = ROW_W + COL_W;
    localparam int DEV_AW = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int WORDS  = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic req_ready, resp_valid, dev_act, dev_pre, dev_rd, dev_wr;
    logic [DATA_W-1:0] resp_rdata, dev_wdata, dev_rdata;
    logic [DEV_AW-1:0] dev_addr;

    dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_ACT(T_ACT),
                    .T_PRE(T_PRE), .T_COL(T_COL), .RD_LAT(RD_LAT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .dev_act(dev_act), .dev_pre(dev_pre), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural bank
    logic [DATA_W-1:0] mem [WORDS];
    logic [ROW_W-1:0]  m_row;
    logic [DATA_W-1:0] m_pipe [RD_LAT];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= DATA_W'(i * 37 + 5);
            for (int i = 0; i < RD_LAT; i++) m_pipe[i] <= '0;
            m_row <= '0;
        end else begin
            if (dev_act) m_row <= dev_addr[ROW_W-1:0];
            if (dev_wr) mem[{m_row, dev_addr[COL_W-1:0]}] <= dev_wdata;
            m_pipe[0] <= dev_rd ? mem[{m_row, dev_addr[COL_W-1:0]}] : '0;
            for (int i = 1; i < RD_LAT; i++) m_pipe[i] <= m_pipe[i-1];
        end
    end
    assign dev_rdata = m_pipe[RD_LAT-1];

    int vec = 0, err = 0, cyc = 0;
    always @(posedge clk) cyc++;

    task automatic chk(input string tag, input int act, input int exp);
        vec++;
        if (act != exp) begin
            err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // command and response log, sampled at the falling edge
    int lg_cyc[$], lg_kind[$], lg_addr[$], lg_data[$];
    int r_cyc[$], r_data[$];
    always @(negedge clk) begin
        if (!rst) begin
            int n;
            n = int'(dev_act) + int'(dev_pre) + int'(dev_rd) + int'(dev_wr);
            if (n > 0) begin
                chk("R2 strobes per cycle", n, 1);
                chk("R9 ready during command", int'(req_ready), 0);
                lg_cyc.push_back(cyc);
                lg_kind.push_back(dev_pre ? 1 : dev_act ? 2 : dev_rd ? 3 : 4);
                lg_addr.push_back(int'(dev_addr));
                lg_data.push_back(int'(dev_wdata));
            end
            if (resp_valid) begin
                r_cyc.push_back(cyc);
                r_data.push_back(int'(resp_rdata));
            end
        end
    end

    int exp_mem [WORDS];
    bit open_v = 1'b0;
    int open_r = 0;
    int last_col = -1000;

    task automatic access(input bit wr, input int row, input int col, input int data);
        int start, rstart, acc, n, ck, tag_n;
        int exp_k[3];
        string tag;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        req_addr  = AW'(row * (1 << COL_W) + col);
        req_wdata = DATA_W'(data);
        start = lg_kind.size(); rstart = r_cyc.size(); acc = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        while (lg_kind.size() == start || lg_kind[lg_kind.size()-1] < 3) @(posedge clk);
        ck = wr ? 4 : 3;
        if (open_v && open_r == row) begin
            tag = "R3 row hit"; tag_n = 1; exp_k[0] = ck;
        end else if (open_v) begin
            tag = "R4 row miss"; tag_n = 3; exp_k[0] = 1; exp_k[1] = 2; exp_k[2] = ck;
        end else begin
            tag = "R1 first access"; tag_n = 2; exp_k[0] = 2; exp_k[1] = ck;
        end
        n = lg_kind.size() - start;
        chk({tag, " command count"}, n, tag_n);
        if (n == tag_n) begin
            for (int i = 0; i < n; i++) chk({tag, " command kind"}, lg_kind[start+i], exp_k[i]);
            chk("R10 first command cycle", lg_cyc[start], acc + 1);
            chk("R6 spacing after column", int'(lg_cyc[start] - last_col >= T_COL), 1);
            if (n == 3) chk("R6 close to open", lg_cyc[start+1] - lg_cyc[start], T_PRE);
            if (n >= 2) begin
                chk("R6 open to column", lg_cyc[start+n-1] - lg_cyc[start+n-2], T_ACT);
                chk("R5 row on address bus", lg_addr[start+n-2], row);
            end
            chk("R5 column on address bus", lg_addr[start+n-1], col);
            if (wr) chk("R7 write data", lg_data[start+n-1], data);
        end
        last_col = lg_cyc[lg_cyc.size()-1];
        open_v = 1'b1; open_r = row;
        if (wr) begin
            exp_mem[row * (1 << COL_W) + col] = data;
        end else begin
            while (r_cyc.size() == rstart) @(posedge clk);
            chk("R8 response delay", r_cyc[rstart] - last_col, RD_LAT);
            chk("R8 read data", r_data[rstart], exp_mem[row * (1 << COL_W) + col]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        err++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) exp_mem[i] = (i * 37 + 5) % 256;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 no strobe after reset", int'(dev_act | dev_pre | dev_rd | dev_wr), 0);
        chk("R1 no response after reset", int'(resp_valid), 0);
        access(1'b0, 5, 2, 0);
        for (int r = 0; r < (1 << ROW_W); r++)
            for (int c = 0; c < (1 << COL_W); c++)
                access(1'b1, r, c, (r * 8 + c) * 3 + 1);
        for (int i = 0; i < WORDS; i++) begin
            int a;
            a = (i * 11) % WORDS;
            access(1'b0, a >> COL_W, a % (1 << COL_W), 0);
        end
        for (int c = 0; c < (1 << COL_W); c++) access(1'b0, 2, c, 0);
        for (int i = 0; i < 12; i++) begin
            access(1'b1, (i * 3) % 8, i % 8, 200 - i * 7);
            access(1'b0, (i * 3) % 8, i % 8, 0);
            access(1'b0, (i * 5 + 1) % 8, (i + 3) % 8, 0);
        end
        repeat (10) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vec, err);
        $finish;
    end
endmodule